// File: doc/BRIEF.md
# Oversampling Serial Receiver with Tagged Receive Queue

This block takes one asynchronous serial input line and turns each character on it into a parallel byte. It counts a timing enable that pulses sixteen times per bit period. A falling edge on the line starts a candidate character. The block checks the line again at the centre of that start bit, then samples every data, parity and stop bit at its own centre. The word length, the parity mode and the number of stop bits are set by static configuration inputs.

Each completed character is stored in a sixteen-entry queue. The entry holds the received bits, right-aligned, together with three flags for that character: parity error, framing error and break. The processor side always sees the oldest entry on the head outputs and removes it with a one-cycle pop. A trigger output rises once the fill count reaches a level chosen by a two-bit code, so the processor can wait for a batch of characters instead of being called for each one. A clear input empties the queue in one cycle. A character that is still arriving when the queue is cleared is not affected.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `fifo_empty` is 1, and `fill_level`, `rx_trig` and `overrun` are all 0.
- R2: A low pulse on `rxd` that has ended before the middle of the start bit (eight ticks after the edge) is rejected. No entry is stored and the receiver returns to hunting for a start edge.
- R3: Data bits arrive least significant bit first. `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The stored byte is right-aligned and its unused upper bits are 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` at 0 the total number of ones in the data and parity bits must be even; with it at 1 the total must be odd. A mismatch sets the entry's parity-error tag.
- R5: `cfg_stop2` at 1 selects two stop bits and at 0 selects one. If any stop sample is low, the entry's framing-error tag is set.
- R6: A character whose data, parity and stop samples are all low is a break. It is stored as one entry with data 0, the break tag at 1, the framing tag at 1 and the parity tag at 0. No further entry is made until `rxd` has returned high.
- R7: The head outputs always show the oldest stored entry, with its own tags. A pop removes that entry, so entries come out in arrival order.
- R8: `rx_trig` is 1 exactly when `fill_level` is at or above the level chosen by `trig_sel`. Codes 0, 1, 2 and 3 select 1, 4, 8 and 14 entries.
- R9: A character that completes while 16 entries are stored is discarded. When that happens, `overrun` is set and stays at 1 until a clear or a reset.
- R10: A one-cycle `fifo_clr` pulse leaves the queue empty and `overrun` at 0 on the next cycle. A character that is being received during the clear is stored normally once its stop bit has been sampled.
- R11: A pop while the queue is empty has no effect. `fill_level` stays at 0 and the next character is stored correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | Enable pulse, sixteen per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_wlen | input | 2 | Word length code (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| trig_sel | input | 2 | Trigger level code (1, 4, 8, 14 entries) |
| fifo_clr | input | 1 | Empty the queue and clear overrun |
| pop | input | 1 | Remove the head entry |
| head_data | output | 8 | Data of the oldest entry |
| head_perr | output | 1 | Parity-error tag of the oldest entry |
| head_ferr | output | 1 | Framing-error tag of the oldest entry |
| head_brk | output | 1 | Break tag of the oldest entry |
| fifo_empty | output | 1 | Queue holds no entry |
| fill_level | output | 5 | Number of stored entries |
| rx_trig | output | 1 | Fill level has reached the trigger level |
| overrun | output | 1 | Sticky flag for a character lost to a full queue |

## Verification
The assertions assume that the configuration inputs do not change while a character is being received, and that `tick16` is a single-cycle pulse at a steady rate. They also assume that pop and clear are single-cycle requests on the system clock. The stimulus changes the configuration only while the line is idle. It generates the tick from a free-running divide-by-four, and it holds each serial bit for exactly sixteen ticks. Pop and clear are driven for one cycle, on the falling clock edge.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } rx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx_s,
  input  logic [1:0] wlen,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      stop2,
  output logic      push,
  output rx_entry_t entry
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  rx_state_t          st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [BW-1:0]      bidx_q, bidx_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic               perr_q, perr_d, ferr_q, ferr_d, zero_q, zero_d;
  logic               sidx_q, sidx_d, prev_q;

  int                 nbits;
  logic [DATA_W-1:0]  aligned;
  logic               exp_par, mid, ferr_fin, zero_fin;

  always_comb begin
    nbits    = DATA_W - 3 + int'(wlen);
    aligned  = sh_q >> (DATA_W - nbits);
    exp_par  = par_odd ? ~^aligned : ^aligned;
    mid      = tick && (cnt_q == ((st_q == ST_START) ? HALF : FULL));
    ferr_fin = ferr_q | ~rx_s;
    zero_fin = zero_q & ~rx_s;
    entry.brk  = zero_fin;
    entry.ferr = ferr_fin;
    entry.perr = perr_q & ~zero_fin;
    entry.data = zero_fin ? '0 : aligned;
  end

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bidx_d = bidx_q; sh_d = sh_q;
    perr_d = perr_q; ferr_d = ferr_q; zero_d = zero_q; sidx_d = sidx_q;
    push = 1'b0;
    if (tick && st_q inside {ST_START, ST_DATA, ST_PAR, ST_STOP})
      cnt_d = cnt_q + 1'b1;
    unique case (st_q)
      ST_IDLE: if (prev_q && !rx_s) begin
        st_d = ST_START; cnt_d = '0; bidx_d = '0; sidx_d = 1'b0;
        perr_d = 1'b0; ferr_d = 1'b0; zero_d = 1'b1;
      end
      ST_START: if (mid) begin
        cnt_d = '0;
        st_d  = rx_s ? ST_IDLE : ST_DATA;
      end
      ST_DATA: if (mid) begin
        cnt_d  = '0;
        sh_d   = {rx_s, sh_q[DATA_W-1:1]};
        zero_d = zero_fin;
        if (bidx_q == BW'(nbits - 1)) begin
          bidx_d = '0;
          st_d   = par_en ? ST_PAR : ST_STOP;
        end else begin
          bidx_d = bidx_q + 1'b1;
        end
      end
      ST_PAR: if (mid) begin
        cnt_d  = '0;
        perr_d = (rx_s != exp_par);
        zero_d = zero_fin;
        st_d   = ST_STOP;
      end
      ST_STOP: if (mid) begin
        cnt_d  = '0;
        ferr_d = ferr_fin;
        zero_d = zero_fin;
        if (stop2 && !sidx_q) begin
          sidx_d = 1'b1;
        end else begin
          push = 1'b1;
          st_d = zero_fin ? ST_BRK : ST_IDLE;
        end
      end
      ST_BRK: if (rx_s) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; bidx_q <= '0; sh_q <= '0;
      perr_q <= 1'b0; ferr_q <= 1'b0; zero_q <= 1'b0; sidx_q <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bidx_q <= bidx_d; sh_q <= sh_d;
      perr_q <= perr_d; ferr_q <= ferr_d; zero_q <= zero_d; sidx_q <= sidx_d;
      prev_q <= rx_s;
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  rx_entry_t        wentry,
  input  logic             pop,
  input  logic             clr,
  input  logic [1:0]       trig_sel,
  output rx_entry_t        head,
  output logic             empty,
  output logic [CNT_W-1:0] fill,
  output logic             trig,
  output logic             ovr
);
  rx_entry_t        mem [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, level;
  logic             ovr_d, full, do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    unique case (trig_sel)
      2'd0:    level = CNT_W'(1);
      2'd1:    level = CNT_W'(DEPTH / 4);
      2'd2:    level = CNT_W'(DEPTH / 2);
      default: level = CNT_W'(DEPTH - 2);
    endcase
    full    = (cnt_q == CNT_W'(DEPTH));
    empty   = (cnt_q == '0);
    do_push = push && !full && !clr;
    do_pop  = pop && !empty && !clr;
    wr_d    = clr ? '0 : (do_push ? nxt(wr_q) : wr_q);
    rd_d    = clr ? '0 : (do_pop ? nxt(rd_q) : rd_q);
    cnt_d   = clr ? '0 : cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    ovr_d   = clr ? 1'b0 : (ovr | (push && full));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0; ovr <= 1'b0;
    end else begin
      wr_q <= wr_d; rd_q <= rd_d; cnt_q <= cnt_d; ovr <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wentry;
  end

  assign head = mem[rd_q];
  assign fill = cnt_q;
  assign trig = (cnt_q >= level);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import srx_pkg::*;
#(
  parameter  int OVS   = 16,
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             rxd,
  input  logic [1:0]       cfg_wlen,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_stop2,
  input  logic [1:0]       trig_sel,
  input  logic             fifo_clr,
  input  logic             pop,
  output logic [7:0]       head_data,
  output logic             head_perr,
  output logic             head_ferr,
  output logic             head_brk,
  output logic             fifo_empty,
  output logic [CNT_W-1:0] fill_level,
  output logic             rx_trig,
  output logic             overrun
);
  logic      rst_q1, rst_core_n, rx_s, push;
  rx_entry_t wentry, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_core_n <= rst_q1;
    end
  end

  srx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d_in(rxd), .d_out(rx_s)
  );

  srx_framer #(.OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_core_n), .tick(tick16), .rx_s(rx_s),
    .wlen(cfg_wlen), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .stop2(cfg_stop2), .push(push), .entry(wentry)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(push), .wentry(wentry),
    .pop(pop), .clr(fifo_clr), .trig_sel(trig_sel), .head(head),
    .empty(fifo_empty), .fill(fill_level), .trig(rx_trig), .ovr(overrun)
  );

  assign head_data = head.data;
  assign head_perr = head.perr;
  assign head_ferr = head.ferr;
  assign head_brk  = head.brk;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pop,
  input logic             fifo_clr,
  input logic [7:0]       head_data,
  input logic             head_ferr,
  input logic             head_brk,
  input logic             fifo_empty,
  input logic [CNT_W-1:0] fill_level,
  input logic             rx_trig,
  input logic             overrun
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH)); // R9
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == CNT_W'(DEPTH) && !pop && !fifo_clr) |=> fill_level == CNT_W'(DEPTH)); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !fifo_clr) |=> overrun); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fifo_empty && !overrun)); // R10
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_clr |=> (fill_level <= $past(fill_level) + 1'b1) && ($past(fill_level) <= fill_level + 1'b1)); // R7
  AST_BRK_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty && head_brk) |-> (head_data == 8'h00 && head_ferr)); // R6
  AST_TRIG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig |-> !fifo_empty); // R8
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pop(pop), .fifo_clr(fifo_clr),
  .head_data(head_data), .head_ferr(head_ferr), .head_brk(head_brk),
  .fifo_empty(fifo_empty), .fill_level(fill_level), .rx_trig(rx_trig),
  .overrun(overrun)
);

// File: tb/uart_rx_fifo_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_bench;
  localparam int BIT = 64; // 16 ticks x 4 clocks
  localparam int NV  = 9;
  // {wlen[24:23], pen[22], podd[21], stop2[20], data[19:12], flip[11], stoplow[10], exp_data[9:2], exp_perr[1], exp_ferr[0]}
  localparam logic [24:0] VEC [NV] = '{
    {2'd3, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 8'hD5, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b1, 8'h2A, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b1, 8'h0F, 1'b0, 1'b1, 8'h0F, 1'b0, 1'b1},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b1, 1'b0, 8'h0B, 1'b1, 1'b0, 8'h0B, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [1:0] div = 2'd0;
  logic tick16;
  logic [1:0] cfg_wlen = 2'd3, trig_sel = 2'd0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic fifo_clr = 1'b0, pop = 1'b0;
  logic [7:0] head_data;
  logic head_perr, head_ferr, head_brk, fifo_empty, rx_trig, overrun;
  logic [4:0] fill_level;
  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign tick16 = (div == 2'd3);

  uart_rx_fifo u_uart_rx_fifo (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .trig_sel(trig_sel), .fifo_clr(fifo_clr), .pop(pop),
    .head_data(head_data), .head_perr(head_perr), .head_ferr(head_ferr),
    .head_brk(head_brk), .fifo_empty(fifo_empty), .fill_level(fill_level),
    .rx_trig(rx_trig), .overrun(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] wl, input logic pe, input logic po, input logic s2,
                            input logic [7:0] d, input logic flip, input logic sl);
    int n;
    logic [7:0] m;
    logic p;
    n = 5 + int'(wl);
    m = 8'hFF >> (8 - n);
    p = po ? ~^(d & m) : ^(d & m);
    if (flip) p = ~p;
    hold(1'b0, BIT);
    for (int i = 0; i < n; i++) hold(d[i], BIT);
    if (pe) hold(p, BIT);
    if (s2) hold(1'b1, BIT);
    hold(!sl, BIT);
    hold(1'b1, 2 * BIT);
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic pe, input logic po, input logic s2);
    @(negedge clk);
    cfg_wlen = wl; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk) fifo_clr = 1'b1;
    @(negedge clk) fifo_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 empty", fifo_empty, 1);
    check("R1 fill", fill_level, 0);
    check("R1 trig", rx_trig, 0);
    check("R1 overrun", overrun, 0);
    hold(1'b1, 2 * BIT);

    // Table walk: R3 word length, R4 parity, R5 stop bits
    for (int v = 0; v < NV; v++) begin
      set_cfg(VEC[v][24:23], VEC[v][22], VEC[v][21], VEC[v][20]);
      send_frame(VEC[v][24:23], VEC[v][22], VEC[v][21], VEC[v][20],
                 VEC[v][19:12], VEC[v][11], VEC[v][10]);
      check("R3 fill", fill_level, 1);
      check("R3 data", head_data, VEC[v][9:2]);
      check("R4 perr", head_perr, VEC[v][1]);
      check("R5 ferr", head_ferr, VEC[v][0]);
      check("R6 brk clear", head_brk, 0);
      do_pop();
    end

    // R2 short low pulse rejected
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    hold(1'b0, 12);
    hold(1'b1, 12 * BIT);
    check("R2 glitch", fill_level, 0);

    // R6 break: 8 data, even parity, 1 stop, line low for 15 bit times
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    hold(1'b0, 15 * BIT);
    hold(1'b1, 3 * BIT);
    check("R6 fill", fill_level, 1);
    check("R6 data", head_data, 8'h00);
    check("R6 brk", head_brk, 1);
    check("R6 ferr", head_ferr, 1);
    check("R6 perr", head_perr, 0);
    do_pop();

    // R8 trigger levels and R7 ordering
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) send_frame(2'd3, 1'b0, 1'b0, 1'b0, 8'h10 + 8'(i), 1'b0, 1'b0);
    check("R8 below 4", rx_trig, 0);
    send_frame(2'd3, 1'b0, 1'b0, 1'b0, 8'h13, 1'b0, 1'b0);
    check("R8 at 4", rx_trig, 1);
    @(negedge clk) trig_sel = 2'd2;
    @(negedge clk);
    check("R8 below 8", rx_trig, 0);
    trig_sel = 2'd0;
    for (int i = 0; i < 4; i++) begin
      check("R7 order", head_data, 8'h10 + 8'(i));
      do_pop();
    end
    check("R7 drained", fifo_empty, 1);

    // R11 pop on empty
    do_pop();
    check("R11 fill", fill_level, 0);
    send_frame(2'd3, 1'b0, 1'b0, 1'b0, 8'h6E, 1'b0, 1'b0);
    check("R11 fill after", fill_level, 1);
    check("R11 data", head_data, 8'h6E);
    do_clr();

    // R9 overrun
    trig_sel = 2'd3;
    for (int i = 0; i < 16; i++) send_frame(2'd3, 1'b0, 1'b0, 1'b0, 8'h40 + 8'(i), 1'b0, 1'b0);
    check("R9 full", fill_level, 16);
    check("R9 no ovr yet", overrun, 0);
    check("R8 at 14", rx_trig, 1);
    send_frame(2'd3, 1'b0, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b0);
    check("R9 fill held", fill_level, 16);
    check("R9 ovr", overrun, 1);
    check("R9 head kept", head_data, 8'h40);

    // R10 clear
    do_clr();
    check("R10 fill", fill_level, 0);
    check("R10 ovr", overrun, 0);
    check("R10 empty", fifo_empty, 1);

    // R10 clear during an incoming character
    send_frame(2'd3, 1'b0, 1'b0, 1'b0, 8'h21, 1'b0, 1'b0);
    send_frame(2'd3, 1'b0, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0);
    check("R10 pre", fill_level, 2);
    fork
      send_frame(2'd3, 1'b0, 1'b0, 1'b0, 8'h99, 1'b0, 1'b0);
      begin
        repeat (5 * BIT) @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk) fifo_clr = 1'b0;
      end
    join
    check("R10 midframe fill", fill_level, 1);
    check("R10 midframe data", head_data, 8'h99);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule